// File: doc/BRIEF.md
# Periodic Interrupt Down-Counter

The block is a 16-bit down-counter that raises a periodic interrupt request. Software reaches it through a small word-addressed data bus. Two registers are mapped there:

- a live count register, which the hardware decrements and reloads;
- a period register, which holds the value loaded into the count at every reload.

The hardware counts down in units of a tick. At elaboration a parameter fixes the tick source: either every clock, or one clock in four from an internal divider. When the count expires, the block emits a one-clock interrupt pulse and starts the next period from the period register. The output is gated by a mask input.

Software controls the current period and the next one separately. Writing the period register changes only the next reload. Writing the count register restarts the current period at once, and the abandoned period raises no interrupt.

Top module: `periodic_irq_timer`

## Requirements
- R1: Both registers are 16 bits wide. A bus write to word address 2 sets the count register, and a write to word address 3 sets the period register. A write to any other address changes neither register.
- R2: When `bus_re` is high at a clock edge, `bus_rdata` holds the value that the addressed register had before that edge, from the next cycle on. Address 2 returns the count and address 3 returns the period. Any other address returns 0.
- R3: While reset is high, the count register is 0xFFFF and `irq_o` is 0. The period register resets to 0xFFFF in every-clock mode (`DIV4_MODE=0`) and to 0x0000 in divided mode (`DIV4_MODE=1`).
- R4: The count drops by one on each tick that is not a reload. In every-clock mode, ticks start at the first clock edge after reset is released. In divided mode, the first tick falls on the fourth edge after release and then on every fourth edge.
- R5: `irq_o` is high for exactly one clock. It rises at the edge where a tick takes the count from 1 to 0.
- R6: In every-clock mode, a tick that finds the count at 0 loads the period value without an interrupt. Pulses therefore repeat every period+1 clocks, so period values 1 to 65535 give intervals of 2 to 65536 clocks.
- R7: In divided mode, a tick that finds the count at 1 loads the period value directly and raises the pulse. Pulses therefore repeat every 4·period clocks.
- R8: A period write leaves the running count unchanged. The new value first takes effect at the next reload.
- R9: A count write restarts counting from the written value, and the interrupted period raises no pulse. A written 0 is reloaded from the period register on the next tick, also without a pulse.
- R10: A count write that falls on the same edge as a decrement or a reload takes precedence. No pulse is raised at that edge.
- R11: While `irq_mask` is high, `irq_o` stays 0. Counting and reloading continue, and the period register still works as a plain read/write storage word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_mask | input | 1 | 1 blocks the interrupt output |
| irq_o | output | 1 | One-clock interrupt pulse |

## Verification
Every result has a fixed delay from its stimulus:

- A write takes effect at the edge that samples it.
- Read data appears one cycle after the edge that samples `bus_re`, and shows the register's value from before that edge.
- An interrupt pulse is visible right after the edge at which the count reaches 0.

The bench drives and samples on the falling edge. It counts falling edges from the edge that took a count write, so the measured number is the count value in every-clock mode. It measures the gap between consecutive pulses to get period+1 in every-clock mode or 4·period in divided mode. The reset reads are placed on known edges, which separates the two tick sources.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_PERIOD = 2'd2
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input int unsigned addr,
                                           input int unsigned cnt_addr,
                                           input int unsigned prd_addr);
    if (addr == cnt_addr)      return SEL_COUNT;
    else if (addr == prd_addr) return SEL_PERIOD;
    else                       return SEL_NONE;
  endfunction

endpackage

// File: rtl/pit_tick_gen.sv
module pit_tick_gen #(
  parameter bit          DIV_EN   = 1'b0,
  parameter int unsigned DIV_LOG2 = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  generate
    if (DIV_EN) begin : g_div
      logic [DIV_LOG2-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
      end
      assign tick = &pre_q;

      // R4: divided ticks never fall on consecutive edges
      p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end else begin : g_every
      assign tick = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/pit_counter_core.sv
module pit_counter_core #(
  parameter int unsigned W          = 16,
  parameter bit          RELOAD_AT1 = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         cnt_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] prd,
  input  logic         mask,
  output logic [W-1:0] cnt,
  output logic         irq
);

  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt_q;
  logic         irq_q;
  logic         expire;
  logic         reload;

  assign expire = tick && (cnt_q == ONE);
  assign reload = tick && ((cnt_q == ZERO) || (RELOAD_AT1 && (cnt_q == ONE)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '1;
      irq_q <= 1'b0;
    end else begin
      if (cnt_wr)      cnt_q <= wdata;
      else if (reload) cnt_q <= prd;
      else if (tick)   cnt_q <= cnt_q - ONE;
      irq_q <= expire && !cnt_wr && !mask;
    end
  end

  assign cnt = cnt_q;
  assign irq = irq_q;

endmodule

// File: rtl/pit_bus_regs.sv
module pit_bus_regs
  import pit_pkg::*;
#(
  parameter int unsigned   W        = 16,
  parameter int unsigned   ADDR_W   = 2,
  parameter int unsigned   CNT_ADDR = 2,
  parameter int unsigned   PRD_ADDR = 3,
  parameter logic [W-1:0]  PRD_RST  = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      cnt,
  output logic [W-1:0]      prd,
  output logic              cnt_wr,
  output logic [W-1:0]      rdata
);

  reg_sel_e     sel;
  logic [W-1:0] prd_q;
  logic [W-1:0] rdata_q;

  assign sel    = decode_addr(int'(addr), CNT_ADDR, PRD_ADDR);
  assign cnt_wr = we && (sel == SEL_COUNT);

  always_ff @(posedge clk) begin
    if (rst)                            prd_q <= PRD_RST;
    else if (we && (sel == SEL_PERIOD)) prd_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (re) begin
      case (sel)
        SEL_COUNT:  rdata_q <= cnt;
        SEL_PERIOD: rdata_q <= prd_q;
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign prd   = prd_q;
  assign rdata = rdata_q;

endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer #(
  parameter int unsigned W         = 16,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned CNT_ADDR  = 2,
  parameter int unsigned PRD_ADDR  = 3,
  parameter bit          DIV4_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic              irq_mask,
  output logic              irq_o
);

  localparam int unsigned  DIV_LOG2 = 2;
  localparam logic [W-1:0] PRD_RST  = DIV4_MODE ? '0 : '1;

  logic         tick;
  logic         cnt_wr;
  logic [W-1:0] cnt;
  logic [W-1:0] prd;

  pit_tick_gen #(.DIV_EN(DIV4_MODE), .DIV_LOG2(DIV_LOG2)) tick_i (
    .clk(clk), .rst(rst), .tick(tick)
  );

  pit_bus_regs #(
    .W(W), .ADDR_W(ADDR_W), .CNT_ADDR(CNT_ADDR), .PRD_ADDR(PRD_ADDR),
    .PRD_RST(PRD_RST)
  ) regs_i (
    .clk(clk), .rst(rst), .we(bus_we), .re(bus_re), .addr(bus_addr),
    .wdata(bus_wdata), .cnt(cnt), .prd(prd), .cnt_wr(cnt_wr),
    .rdata(bus_rdata)
  );

  pit_counter_core #(.W(W), .RELOAD_AT1(DIV4_MODE)) core_i (
    .clk(clk), .rst(rst), .tick(tick), .cnt_wr(cnt_wr), .wdata(bus_wdata),
    .prd(prd), .mask(irq_mask), .cnt(cnt), .irq(irq_o)
  );

  // R5: interrupt is a single-clock pulse
  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  // R11: mask keeps the output low
  p_mask_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    irq_mask |=> !irq_o);

  // R10: a count write lands and suppresses the pulse
  p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (bus_addr == ADDR_W'(CNT_ADDR))) |=>
      (!irq_o && (cnt == $past(bus_wdata))));

  // R8: period changes only through a bus write
  p_prd_keep_r8: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && (bus_addr == ADDR_W'(PRD_ADDR))) |=> $stable(prd));

  // R2: count read returns the pre-edge value one cycle later
  p_read_cnt_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_re && (bus_addr == ADDR_W'(CNT_ADDR))) |=> (bus_rdata == $past(cnt)));

  generate
    if (!DIV4_MODE) begin : g_ec_chk
      // R5: in every-clock mode the pulse coincides with a zero count
      p_irq_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (cnt == '0));
    end
  endgenerate

endmodule

// File: tb/periodic_irq_timer_tb_top.sv
module periodic_irq_timer_tb_top;

  localparam int LIMIT = 4000;

  typedef struct packed {
    logic [15:0] prd;
    logic [15:0] cnt;
    logic [15:0] first;
    logic [15:0] second;
  } vec_t;

  // every-clock mode: first pulse = cnt edges after the write (cnt 0 -> prd+1), then prd+1
  localparam vec_t VEC [0:4] = '{
    '{16'd5,  16'd3,  16'd3,  16'd6},
    '{16'd1,  16'd1,  16'd1,  16'd2},
    '{16'd10, 16'd0,  16'd11, 16'd11},
    '{16'd2,  16'd7,  16'd7,  16'd3},
    '{16'd40, 16'd25, 16'd25, 16'd41}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        irq_mask = 1'b0;
  logic [15:0] rd_ec, rd_ps;
  logic        irq_ec, irq_ps;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  periodic_irq_timer #(.DIV4_MODE(1'b0)) dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_ec),
    .irq_mask(irq_mask), .irq_o(irq_ec)
  );

  periodic_irq_timer #(.DIV4_MODE(1'b1)) dut_ps_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_ps),
    .irq_mask(irq_mask), .irq_o(irq_ps)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  function automatic logic irq_of(input bit ps);
    return ps ? irq_ps : irq_ec;
  endfunction

  task automatic wait_from(input bit ps, input int start, output int n);
    n = start;
    while (!irq_of(ps) && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_next(input bit ps, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq_of(ps) && n < LIMIT);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R3 irq low in reset", int'(irq_ec), 0);
    check("R3 irq low in reset (div)", int'(irq_ps), 0);
    rst = 1'b0;
    bus_read(2'd2);
    check("R3 count reset", int'(rd_ec), 16'hFFFF);
    check("R3 count reset (div)", int'(rd_ps), 16'hFFFF);
    bus_read(2'd3);
    check("R3 period reset", int'(rd_ec), 16'hFFFF);
    check("R3 period reset (div)", int'(rd_ps), 0);
    bus_read(2'd2);
    check("R4 every-clock decrement", int'(rd_ec), 16'hFFFD);
    check("R4 no divided tick yet", int'(rd_ps), 16'hFFFF);
    bus_read(2'd0);
    check("R2 unmapped read", int'(rd_ec), 0);
    bus_read(2'd2);
    check("R4 every-clock count", int'(rd_ec), 16'hFFFB);
    check("R4 first divided tick", int'(rd_ps), 16'hFFFE);

    // vector table: R5/R6/R9
    foreach (VEC[i]) begin
      bus_write(2'd3, VEC[i].prd);
      bus_write(2'd2, VEC[i].cnt);
      wait_from(1'b0, 0, n);
      check("R6 first pulse after count write (R9)", n, int'(VEC[i].first));
      wait_next(1'b0, n);
      check("R6 R5 pulse interval prd+1", n, int'(VEC[i].second));
    end

    // R8: period write mid-count
    bus_write(2'd3, 16'd20);
    bus_write(2'd2, 16'd10);
    @(negedge clk); @(negedge clk);
    bus_write(2'd3, 16'd4);
    wait_from(1'b0, 3, n);
    check("R8 current count undisturbed", n, 10);
    wait_next(1'b0, n);
    check("R8 new period at reload", n, 5);

    // R10: count write on the expiring edge
    bus_write(2'd3, 16'd30);
    bus_write(2'd2, 16'd3);
    @(negedge clk); @(negedge clk);
    bus_write(2'd2, 16'd8);
    wait_from(1'b0, 3, n);
    check("R10 write wins, no pulse", n, 11);

    // R11: mask
    irq_mask = 1'b1;
    bus_write(2'd3, 16'd3);
    bus_write(2'd2, 16'd2);
    n = 0;
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      if (irq_ec) n++;
    end
    check("R11 masked output quiet", n, 0);
    bus_read(2'd2);
    check("R11 counting continues masked", int'(rd_ec), 1);
    bus_write(2'd3, 16'hABCD);
    bus_write(2'd1, 16'h1234);
    bus_read(2'd3);
    check("R11 R1 period as storage", int'(rd_ec), 16'hABCD);
    irq_mask = 1'b0;

    // R7: divided mode intervals
    bus_write(2'd3, 16'd3);
    bus_write(2'd2, 16'd3);
    wait_from(1'b1, 0, n);
    wait_next(1'b1, n);
    check("R7 divided interval 4*prd", n, 12);
    bus_write(2'd3, 16'd1);
    bus_write(2'd2, 16'd1);
    wait_from(1'b1, 0, n);
    wait_next(1'b1, n);
    check("R7 divided interval prd=1", n, 4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule